// File: doc/BRIEF.md
# Multi-Block DMA Boundary Sequencer

This block steps a multi-block card transfer that writes to or reads from system memory under a DMA address. When a transfer starts it captures the start address, the block count and the block length. It then works out how many bytes remain before the next power-of-two DMA buffer boundary. Each block-complete pulse from the data path moves the address forward by one block length. The same pulse lowers the block count by one and lowers the distance to the boundary by one block length.

When the distance to the boundary reaches zero and DMA interrupts are enabled, the sequencer pauses before the next block and raises a DMA-boundary flag. Software can then reprogram the buffer and resume the transfer. When the last block finishes, the sequencer raises a transfer-complete flag instead. Both flags stay set until software clears them.

The controller has three states:
- `ST_IDLE`: waiting for a start.
- `ST_RUN`: counting blocks.
- `ST_PAUSE`: stopped at a buffer boundary.

It has four transitions:
- *launch* (IDLE→RUN): `start` with a nonzero block count.
- *finish* (RUN→IDLE): the last block is done.
- *suspend* (RUN→PAUSE): a boundary stop.
- *resume* (PAUSE→RUN): `resume` is pulsed.

Top module: `dma_bndry_seq`

## Requirements
- R1: After reset the sequencer is idle. `busy`, `paused`, both flags, `cur_addr`, `blks_left` and `bnd_left` are all zero.
- R2: A `start` in idle with a nonzero block count loads the following values. `cur_addr` takes `start_addr` and `blks_left` takes `blk_cnt_reg`. `bnd_left` takes S − (`start_addr` mod S). Here S = 2^(code+12) and code is `blk_size_reg[15:12]`.
- R3: Each `blk_done` while running does three things. `cur_addr` rises by the block length, which is `blk_size_reg[11:0]` captured at start. `bnd_left` falls by the same amount. `blks_left` falls by one.
- R4: When `blks_left` reaches zero, the sequencer returns to idle and sets `flag_cmpl`.
- R5: The sequencer pauses in one case only. The start count was greater than one, `dma_irq_en` is high at the `blk_done`, `bnd_left` becomes zero, and blocks remain. It then enters PAUSE (`paused`=1, `busy`=0) and sets `flag_dma`. It does not set `flag_cmpl`.
- R6: With `dma_irq_en` low, reaching the boundary does not pause the transfer.
- R7: A single-block transfer never pauses at the boundary. It ends with `flag_cmpl` set and `flag_dma` clear, even if its block ends exactly on the boundary.
- R8: A `resume` pulse while paused returns the sequencer to RUN and reloads `bnd_left` with the full size S.
- R9: The flags are sticky. `sts_clr[0]` clears `flag_cmpl` and `sts_clr[1]` clears `flag_dma`. A set and a clear in the same cycle leave the flag set.
- R10: These inputs are ignored: `blk_done` outside RUN, `start` outside IDLE, and `start` with a zero block count. The address and counts keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (pulse) |
| blk_size_reg | input | 16 | [11:0] block length in bytes, [15:12] boundary code |
| blk_cnt_reg | input | CNT_W | Number of blocks |
| start_addr | input | ADDR_W | System DMA start address |
| dma_irq_en | input | 1 | Enables pausing at a buffer boundary |
| blk_done | input | 1 | One block finished by the data path (pulse) |
| resume | input | 1 | Continue after a boundary pause (pulse) |
| sts_clr | input | 2 | Write-one-to-clear: [0] complete, [1] DMA boundary |
| cur_addr | output | ADDR_W | Current DMA address |
| blks_left | output | CNT_W | Blocks still to transfer |
| bnd_left | output | ADDR_W | Bytes left before the buffer boundary |
| busy | output | 1 | State is RUN |
| paused | output | 1 | State is PAUSE |
| flag_cmpl | output | 1 | Transfer-complete status |
| flag_dma | output | 1 | DMA-boundary status |

## Verification
Every result is held in a register, so an input driven before a rising edge shows at the outputs just after that edge. This applies to the addresses, counts, state outputs and flags alike. The bench drives each pulse on a falling edge, holds it for one cycle, and samples at the next falling edge, exactly one clock after the stimulus. Checks on ignored inputs sample at that same point and compare against the values held before the pulse.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
    localparam int LEN_W      = 12;
    localparam int CODE_LSB   = 12;
    localparam int CODE_W     = 4;
    localparam int BASE_SHIFT = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } dbt_state_e;
endpackage

// File: rtl/dbt_bound_calc.sv
module dbt_bound_calc
    import dbt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [CODE_W-1:0] code,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] win_size,
    output logic [ADDR_W-1:0] win_rem
);
    localparam int SHIFT_W = $clog2(ADDR_W);

    logic [SHIFT_W-1:0] shamt;

    always_comb begin
        shamt    = SHIFT_W'(code) + SHIFT_W'(BASE_SHIFT);
        win_size = {{(ADDR_W-1){1'b0}}, 1'b1} << shamt;
        win_rem  = win_size - (addr & (win_size - 1'b1));
    end

    initial begin
        // R2
        size_fit_chk: assert (ADDR_W > (1 << CODE_W) - 1 + BASE_SHIFT);
    end
endmodule

// File: rtl/dbt_status.sv
module dbt_status #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    output logic [NFLAG-1:0] flags
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;
            else if (clr[i])
                flags[i] <= 1'b0;
        end

        // R9
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !clr[i]) |=> flags[i]);
        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
    end
endmodule

// File: rtl/dma_bndry_seq.sv
module dma_bndry_seq
    import dbt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       blk_size_reg,
    input  logic [CNT_W-1:0]  blk_cnt_reg,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              dma_irq_en,
    input  logic              blk_done,
    input  logic              resume,
    input  logic [1:0]        sts_clr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  blks_left,
    output logic [ADDR_W-1:0] bnd_left,
    output logic              busy,
    output logic              paused,
    output logic              flag_cmpl,
    output logic              flag_dma
);
    localparam int IDX_CMPL = 0;
    localparam int IDX_DMA  = 1;

    dbt_state_e state_q, state_d;

    logic [LEN_W-1:0]  len_q;
    logic [ADDR_W-1:0] size_q;
    logic              multi_q;
    logic [ADDR_W-1:0] calc_size, calc_rem;
    logic [ADDR_W-1:0] len_ext;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [ADDR_W-1:0] rem_nxt;
    logic              launch, step, last_blk, stop_bnd;
    logic [1:0]        set_vec, flag_vec;

    dbt_bound_calc #(.ADDR_W(ADDR_W)) bound_i (
        .code     (blk_size_reg[CODE_LSB +: CODE_W]),
        .addr     (start_addr),
        .win_size (calc_size),
        .win_rem  (calc_rem)
    );

    always_comb begin
        len_ext  = {{(ADDR_W-LEN_W){1'b0}}, len_q};
        cnt_nxt  = blks_left - 1'b1;
        rem_nxt  = bnd_left - len_ext;
        launch   = (state_q == ST_IDLE) && start && (blk_cnt_reg != '0);
        step     = (state_q == ST_RUN) && blk_done;
        last_blk = (cnt_nxt == '0);
        stop_bnd = multi_q && dma_irq_en && (rem_nxt == '0) && !last_blk;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_RUN;
            ST_RUN:   if (step && last_blk)      state_d = ST_IDLE;
                      else if (step && stop_bnd) state_d = ST_PAUSE;
            ST_PAUSE: if (resume) state_d = ST_RUN;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // address, counts and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            blks_left <= '0;
            bnd_left  <= '0;
            len_q     <= '0;
            size_q    <= '0;
            multi_q   <= 1'b0;
        end else if (launch) begin
            cur_addr  <= start_addr;
            blks_left <= blk_cnt_reg;
            bnd_left  <= calc_rem;
            len_q     <= blk_size_reg[LEN_W-1:0];
            size_q    <= calc_size;
            multi_q   <= (blk_cnt_reg > CNT_W'(1));
        end else if (step) begin
            cur_addr  <= cur_addr + len_ext;
            blks_left <= cnt_nxt;
            bnd_left  <= rem_nxt;
        end else if ((state_q == ST_PAUSE) && resume) begin
            bnd_left  <= size_q;
        end
    end

    assign busy   = (state_q == ST_RUN);
    assign paused = (state_q == ST_PAUSE);

    assign set_vec[IDX_CMPL] = step && last_blk;
    assign set_vec[IDX_DMA]  = step && stop_bnd;

    dbt_status #(.NFLAG(2)) status_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_vec),
        .clr   (sts_clr),
        .flags (flag_vec)
    );

    assign flag_cmpl = flag_vec[IDX_CMPL];
    assign flag_dma  = flag_vec[IDX_DMA];

    // R3
    blk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && blk_done) |=> (blks_left == $past(blks_left) - 1'b1));
    // R4
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && blk_done && blks_left == CNT_W'(1)) |=> (flag_cmpl && !busy && !paused));
    // R8
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && resume) |=> (busy && bnd_left == size_q));
    // R10
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !resume) |=> ($stable(cur_addr) && $stable(blks_left)));
    // R5
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && paused));
endmodule

// File: tb/dma_bndry_seq_tb_top.sv
module dma_bndry_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 4;

    // {blk_size, blk_cnt, start_addr, expected bnd_left, expected final addr}
    localparam logic [127:0] VEC [NVEC] = '{
        {16'h0200, 16'd2, 32'h1000_0000, 32'h0000_1000, 32'h1000_0400},
        {16'h1200, 16'd3, 32'h0000_1100, 32'h0000_0F00, 32'h0000_1700},
        {16'h7040, 16'd3, 32'h0007_FFC0, 32'h0000_0040, 32'h0008_0080},
        {16'h0004, 16'd5, 32'h0000_0123, 32'h0000_0EDD, 32'h0000_0137}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] blk_size_reg = '0;
    logic [15:0] blk_cnt_reg = '0;
    logic [31:0] start_addr = '0;
    logic        dma_irq_en = 1'b0;
    logic        blk_done = 1'b0;
    logic        resume = 1'b0;
    logic [1:0]  sts_clr = '0;
    logic [31:0] cur_addr, bnd_left;
    logic [15:0] blks_left;
    logic        busy, paused, flag_cmpl, flag_dma;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_bndry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_size_reg(blk_size_reg),
        .blk_cnt_reg(blk_cnt_reg), .start_addr(start_addr), .dma_irq_en(dma_irq_en),
        .blk_done(blk_done), .resume(resume), .sts_clr(sts_clr),
        .cur_addr(cur_addr), .blks_left(blks_left), .bnd_left(bnd_left),
        .busy(busy), .paused(paused), .flag_cmpl(flag_cmpl), .flag_dma(flag_dma)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [15:0] sz, input logic [15:0] cnt, input logic [31:0] a);
        blk_size_reg = sz; blk_cnt_reg = cnt; start_addr = a; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_done(input logic [1:0] clr);
        blk_done = 1'b1; sts_clr = clr;
        @(negedge clk); blk_done = 1'b0; sts_clr = 2'b00;
    endtask

    task automatic do_clr(input logic [1:0] clr);
        sts_clr = clr;
        @(negedge clk); sts_clr = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 paused", {31'd0, paused}, 32'd0);
        chk("R1 flags", {30'd0, flag_cmpl, flag_dma}, 32'd0);
        chk("R1 addr", cur_addr, 32'd0);
        chk("R1 cnt", {16'd0, blks_left}, 32'd0);
        chk("R1 bnd", bnd_left, 32'd0);

        // table walk with DMA interrupts disabled: R2, R3, R4, R6
        dma_irq_en = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            do_start(VEC[v][127:112], VEC[v][111:96], VEC[v][95:64]);
            chk("R2 addr", cur_addr, VEC[v][95:64]);
            chk("R2 cnt", {16'd0, blks_left}, {16'd0, VEC[v][111:96]});
            chk("R2 bnd", bnd_left, VEC[v][63:32]);
            chk("R2 busy", {31'd0, busy}, 32'd1);
            for (int b = 0; b < int'(VEC[v][111:96]); b++) begin
                do_done(2'b00);
                chk("R6 no pause", {31'd0, paused}, 32'd0);
                chk("R3 bnd step", bnd_left,
                    VEC[v][63:32] - 32'(b + 1) * {20'd0, VEC[v][123:112]});
            end
            chk("R3 final addr", cur_addr, VEC[v][31:0]);
            chk("R4 cnt zero", {16'd0, blks_left}, 32'd0);
            chk("R4 idle", {30'd0, busy, paused}, 32'd0);
            chk("R4 cmpl", {31'd0, flag_cmpl}, 32'd1);
            chk("R6 no dma", {31'd0, flag_dma}, 32'd0);
            do_clr(2'b01);
            chk("R9 w1c", {31'd0, flag_cmpl}, 32'd0);
        end

        // R10 zero block count start ignored
        do_start(16'h0200, 16'd0, 32'h5555_0000);
        chk("R10 zero cnt", {31'd0, busy}, 32'd0);
        chk("R10 zero cnt addr", cur_addr, 32'h0000_0137);
        // R10 done while idle ignored
        do_done(2'b00);
        chk("R10 idle done", cur_addr, 32'h0000_0137);

        // boundary pause: R5, R8, R9, R10
        dma_irq_en = 1'b1;
        do_start(16'h0400, 16'd6, 32'h2000_0800);
        chk("R2 bnd pause case", bnd_left, 32'd2048);
        do_start(16'h0004, 16'd9, 32'h0);
        chk("R10 start in run", cur_addr, 32'h2000_0800);
        do_done(2'b00);
        chk("R3 addr", cur_addr, 32'h2000_0C00);
        chk("R3 bnd", bnd_left, 32'd1024);
        chk("R5 still run", {31'd0, busy}, 32'd1);
        do_done(2'b00);
        chk("R5 paused", {30'd0, busy, paused}, 32'd1);
        chk("R5 dma flag", {31'd0, flag_dma}, 32'd1);
        chk("R5 no cmpl", {31'd0, flag_cmpl}, 32'd0);
        chk("R5 cnt", {16'd0, blks_left}, 32'd4);
        do_done(2'b00);
        chk("R10 pause done addr", cur_addr, 32'h2000_1000);
        chk("R10 pause done cnt", {16'd0, blks_left}, 32'd4);
        resume = 1'b1; @(negedge clk); resume = 1'b0;
        chk("R8 run", {30'd0, busy, paused}, 32'd2);
        chk("R8 reload", bnd_left, 32'd4096);
        chk("R9 dma sticky", {31'd0, flag_dma}, 32'd1);
        do_clr(2'b10);
        chk("R9 dma cleared", {31'd0, flag_dma}, 32'd0);
        do_done(2'b00); do_done(2'b00); do_done(2'b00);
        do_done(2'b01);
        chk("R4 resumed end addr", cur_addr, 32'h2000_2000);
        chk("R9 set wins", {31'd0, flag_cmpl}, 32'd1);
        chk("R4 end on bnd not dma", {31'd0, flag_dma}, 32'd0);
        chk("R4 idle", {30'd0, busy, paused}, 32'd0);
        do_clr(2'b01);

        // R7 single block ending exactly on the boundary
        do_start(16'h0800, 16'd1, 32'h0000_0800);
        chk("R7 bnd", bnd_left, 32'd2048);
        do_done(2'b00);
        chk("R7 bnd zero", bnd_left, 32'd0);
        chk("R7 cmpl", {31'd0, flag_cmpl}, 32'd1);
        chk("R7 no dma", {31'd0, flag_dma}, 32'd0);
        chk("R7 idle", {30'd0, busy, paused}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule